// File: doc/BRIEF.md
# Socket Interrupt Aggregator with Re-assert Hold-off

This block gathers the interrupt status of eight network sockets into one pending summary and drives a single active-low interrupt line to a host processor. Each socket owns an 8-bit status register. Event strobes from the socket logic set its bits, and the host clears them by writing ones. A summary bit is 1 while its socket has any status bit set. The summary bit drops by itself once the host has cleared that socket's status to zero.

The interrupt line is low while any summary bit is set. When the line is released, a programmable 16-bit interval holds it high for at least (interval + 1) × 4 clock cycles before it may go low again. This gives the host a quiet window after it has serviced every socket. If work is still pending when the window ends, the line goes low on the cycle the window ends. If new work arrives later, the line goes low one cycle after it arrives.

The host sees a small register port with one-cycle registered reads. Addresses 0 to 7 are the socket status registers, which are write-1-to-clear. Address 8 is the read-only summary. Addresses 9 and 10 hold the low and high bytes of the interval.

Top module: `sock_irq_agg`

## Requirements
- R1: After reset every socket status register and the summary read as 0x00, `irq_n` is 1, and the interval reads 0x000F (address 9 = 0x0F, address 10 = 0x00).
- R2: An event bit k on socket n (`evt_set[n*8+k]`) sets bit k of status register n at the next clock edge. Summary bit n (address 8) reads 1 exactly when status register n is nonzero.
- R3: A write to address n (0 to 7) clears the status bits written as 1. Bits written as 0 are unchanged.
- R4: When an event and a host clear hit the same status bit in the same cycle, the bit ends up set.
- R5: Writes to the summary address 8 have no effect on the summary.
- R6: When no hold-off window is running, `irq_n` goes low at the clock edge after the summary becomes nonzero. It stays low while the summary is nonzero.
- R7: `irq_n` goes high at the clock edge after the summary becomes zero.
- R8: After `irq_n` rises, it stays high for (interval + 1) × 4 cycles. If the summary is nonzero when that window ends, `irq_n` goes low exactly (interval + 1) × 4 cycles after it rose.
- R9: Address 9 holds interval bits 7:0 and address 10 holds interval bits 15:8. Both are writable and read back.
- R10: `bus_rdata` is loaded at the edge where `bus_rd` is high, with the value the register held before that edge. Addresses 11 to 15 read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 64 | Event strobes, byte n for socket n |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 4 | Host register address |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data |
| irq_n | output | 1 | Active-low interrupt to the host |

## Verification
The hardest case to reach is a socket that raises a fresh event while the hold-off window is running. The host must clear the last pending socket, and on the very next cycle an event must make the summary nonzero again. The line then has to stay high for the whole programmed window before it falls. The bench drives the clear write and the event strobe on consecutive cycles for two interval values, and counts the high cycles. It also reaches a second case, where the window expires with nothing pending and a later event must pull the line low with no extra delay.

// File: rtl/sia_pkg.sv
package sia_pkg;
  typedef enum logic [1:0] {
    LINE_IDLE = 2'd0,
    LINE_ACT  = 2'd1,
    LINE_HOLD = 2'd2
  } line_st_t;
endpackage

// File: rtl/sia_sock_stat.sv
module sia_sock_stat #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] stat,
  output logic         pend
);
  logic [W-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr_eff) | evt;
  end

  assign pend = |stat;

  // R2, R4: an event bit is set after the edge, whatever the clear did
  p_evt_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  // R3: bits written as one without a competing event are cleared
  p_w1c_r3: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> ((stat & $past(clr_mask & ~evt)) == '0));
endmodule

// File: rtl/sia_hold_timer.sv
module sia_hold_timer
  import sia_pkg::*;
#(
  parameter int unsigned IVL_W = 16,
  parameter int unsigned PRESC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend_any,
  input  logic [IVL_W-1:0] ivl,
  output logic             irq_n
);
  localparam int unsigned CNT_W = IVL_W + $clog2(PRESC) + 1;

  line_st_t   st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] load_val;

  assign load_val = (CNT_W'(ivl) + CNT_W'(1)) * CNT_W'(PRESC) - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= LINE_IDLE;
      cnt   <= '0;
      irq_n <= 1'b1;
    end else begin
      unique case (st)
        LINE_IDLE: begin
          if (pend_any) begin
            st    <= LINE_ACT;
            irq_n <= 1'b0;
          end
        end
        LINE_ACT: begin
          if (!pend_any) begin
            st    <= LINE_HOLD;
            irq_n <= 1'b1;
            cnt   <= load_val;
          end
        end
        LINE_HOLD: begin
          if (cnt == '0) begin
            if (pend_any) begin
              st    <= LINE_ACT;
              irq_n <= 1'b0;
            end else begin
              st <= LINE_IDLE;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        default: begin
          st    <= LINE_IDLE;
          irq_n <= 1'b1;
        end
      endcase
    end
  end

  // R7: with nothing pending, a low line is released at the next edge
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !pend_any) |=> irq_n);

  // R6: a low line always has pending work behind it
  p_low_has_pend_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n) |-> $past(pend_any));

  // R6: outside the hold window, pending work pulls the line low at once
  p_assert_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (st == LINE_IDLE && pend_any) |=> !irq_n);

  // R8: a rising line always starts a hold window
  p_rise_holds_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_n) |-> (st == LINE_HOLD));
endmodule

// File: rtl/sock_irq_agg.sv
module sock_irq_agg #(
  parameter int unsigned NUM_SOCK = 8,
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned IVL_W    = 16,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned PRESC    = 4,
  parameter logic [IVL_W-1:0] IVL_RST = 16'h000F
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SOCK*DATA_W-1:0]   evt_set,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         irq_n
);
  localparam int unsigned SEL_W     = $clog2(NUM_SOCK);
  localparam int unsigned IVL_BYTES = IVL_W / DATA_W;
  localparam int unsigned A_SUM     = NUM_SOCK;
  localparam int unsigned A_IVL     = NUM_SOCK + 1;
  localparam int unsigned A_LAST    = A_IVL + IVL_BYTES - 1;

  logic [DATA_W-1:0]   stat_arr [NUM_SOCK];
  logic [NUM_SOCK-1:0] summary;
  logic [IVL_W-1:0]    ivl_q;

  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
    sia_sock_stat #(.W(DATA_W)) u_stat (
      .clk      (clk),
      .rst      (rst),
      .evt      (evt_set[g*DATA_W +: DATA_W]),
      .clr_we   (bus_wr && (bus_addr == ADDR_W'(g))),
      .clr_mask (bus_wdata),
      .stat     (stat_arr[g]),
      .pend     (summary[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ivl_q <= IVL_RST;
    end else if (bus_wr) begin
      for (int b = 0; b < IVL_BYTES; b++) begin
        if (bus_addr == ADDR_W'(A_IVL + b)) ivl_q[b*DATA_W +: DATA_W] <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= '0;
      if (bus_addr < ADDR_W'(NUM_SOCK)) begin
        bus_rdata <= stat_arr[bus_addr[SEL_W-1:0]];
      end else if (bus_addr == ADDR_W'(A_SUM)) begin
        bus_rdata <= DATA_W'(summary);
      end else begin
        for (int b = 0; b < IVL_BYTES; b++) begin
          if (bus_addr == ADDR_W'(A_IVL + b)) bus_rdata <= ivl_q[b*DATA_W +: DATA_W];
        end
      end
    end
  end

  sia_hold_timer #(.IVL_W(IVL_W), .PRESC(PRESC)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .pend_any (|summary),
    .ivl      (ivl_q),
    .irq_n    (irq_n)
  );

  // R5: a summary-address write with no events leaves the summary alone
  p_sum_ro_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(A_SUM) && evt_set == '0) |=> (summary == $past(summary)));

  // R10: reads beyond the map return zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr > ADDR_W'(A_LAST)) |=> (bus_rdata == '0));

  // R10: read data only changes on a read
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/sock_irq_agg_tb.sv
module sock_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] evt_set = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_n;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sock_irq_agg u_dut (
    .clk(clk), .rst(rst), .evt_set(evt_set), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_n(irq_n)
  );

  // behavioural reference model
  int m_st [8];
  int m_ivl;
  int m_line;
  int m_wait;
  int m_rd;

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_st[i]) m_st[i] = 0;
      m_ivl = 15; m_line = 1; m_wait = -1; m_rd = 0;
    end else begin
      int any;
      any = 0;
      foreach (m_st[i]) if (m_st[i] != 0) any = 1;
      if (bus_rd) begin
        if (bus_addr < 8) m_rd = m_st[bus_addr];
        else if (bus_addr == 8) begin
          m_rd = 0;
          foreach (m_st[i]) if (m_st[i] != 0) m_rd += (1 << i);
        end
        else if (bus_addr == 9) m_rd = m_ivl & 8'hFF;
        else if (bus_addr == 10) m_rd = (m_ivl >> 8) & 8'hFF;
        else m_rd = 0;
      end
      if (m_line == 0) begin
        if (!any) begin m_line = 1; m_wait = (m_ivl + 1) * 4 - 1; end
      end else if (m_wait > 0) m_wait--;
      else if (m_wait == 0) begin
        if (any) m_line = 0;
        m_wait = -1;
      end else if (any) m_line = 0;
      for (int s = 0; s < 8; s++) begin
        if (bus_wr && bus_addr == s) m_st[s] = m_st[s] & ~int'(bus_wdata);
        m_st[s] = m_st[s] | int'(evt_set[s*8 +: 8]);
      end
      if (bus_wr && bus_addr == 9)  m_ivl = (m_ivl & 16'hFF00) | int'(bus_wdata);
      if (bus_wr && bus_addr == 10) m_ivl = (m_ivl & 16'h00FF) | (int'(bus_wdata) << 8);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && !done) begin
      chk(int'(irq_n), m_line, "R6/R7/R8 model irq_n");
      chk(int'(bus_rdata), m_rd, "R10 model rdata");
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1 d = int'(bus_rdata);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ev(input int s, input logic [7:0] bits);
    @(negedge clk); evt_set[s*8 +: 8] = bits;
    @(negedge clk); evt_set = '0;
  endtask

  task automatic clear_then_event(output int hi);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h01;
    @(negedge clk); bus_wr = 1'b0; evt_set[8] = 1'b1;
    @(negedge clk); evt_set = '0;
    hi = 0;
    while (irq_n == 1'b1 && hi < 1000) begin hi++; @(negedge clk); end
  endtask

  initial begin
    int d;
    int hi;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(int'(irq_n), 1, "R1 irq_n after reset");
    rd(4'd8, d);  chk(d, 0, "R1 summary after reset");
    rd(4'd0, d);  chk(d, 0, "R1 socket0 after reset");
    rd(4'd9, d);  chk(d, 8'h0F, "R1 R9 interval low reset");
    rd(4'd10, d); chk(d, 0, "R1 interval high reset");

    wr(4'd10, 8'h12); rd(4'd10, d); chk(d, 8'h12, "R9 interval high write");
    wr(4'd10, 8'h00); wr(4'd9, 8'h00); rd(4'd9, d); chk(d, 0, "R9 interval low write");

    ev(0, 8'h08); @(negedge clk);
    chk(int'(irq_n), 0, "R6 irq_n low after event");
    rd(4'd0, d); chk(d, 8'h08, "R2 socket0 status bit3");
    rd(4'd8, d); chk(d, 8'h01, "R2 summary bit0");
    ev(1, 8'h01);
    rd(4'd8, d); chk(d, 8'h03, "R2 summary bits 0 and 1");

    wr(4'd8, 8'hFF); rd(4'd8, d); chk(d, 8'h03, "R5 summary write ignored");
    wr(4'd8, 8'h00); rd(4'd8, d); chk(d, 8'h03, "R5 summary zero write ignored");

    wr(4'd0, 8'h00); rd(4'd0, d); chk(d, 8'h08, "R3 zero write keeps bits");
    wr(4'd0, 8'h08); rd(4'd8, d); chk(d, 8'h02, "R3 socket0 cleared, summary bit0 drops");
    chk(int'(irq_n), 0, "R6 irq_n stays low with socket1 pending");

    clear_then_event(hi); chk(hi, 4, "R8 hold width interval 0");
    wr(4'd9, 8'h02);
    clear_then_event(hi); chk(hi, 12, "R8 hold width interval 2");

    wr(4'd1, 8'h01); @(negedge clk);
    chk(int'(irq_n), 1, "R7 irq_n high after last clear");
    repeat (20) @(negedge clk);
    chk(int'(irq_n), 1, "R7 irq_n high with nothing pending");
    ev(2, 8'h40); @(negedge clk);
    chk(int'(irq_n), 0, "R8 late event asserts at once");

    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 8'h40; evt_set[2*8+6] = 1'b1;
    @(negedge clk); bus_wr = 1'b0; evt_set = '0;
    rd(4'd2, d); chk(d, 8'h40, "R4 event wins over clear");
    @(negedge clk); bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 8'h40; evt_set[2*8] = 1'b1;
    @(negedge clk); bus_wr = 1'b0; evt_set = '0;
    rd(4'd2, d); chk(d, 8'h01, "R3 R4 clear one bit, event another");

    rd(4'd15, d); chk(d, 0, "R10 unmapped address 15");
    rd(4'd11, d); chk(d, 0, "R10 unmapped address 11");

    wr(4'd2, 8'hFF); @(negedge clk);
    chk(int'(irq_n), 1, "R7 release after full clear");
    rd(4'd8, d); chk(d, 0, "R2 summary empty");

    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule